// File: doc/BRIEF.md
# Cross-Interleaved Two-Stage Reed-Solomon Encoder

This block protects a symbol stream against long error bursts. Each frame of 24 eight-bit data symbols first receives four Reed-Solomon check symbols. The resulting 28 symbols are then spread over later frames by a convolutional interleaver whose deepest lane spans 27 frames. Finally, each 28-symbol interleaved frame receives four more check symbols. The result is a 32-symbol output frame. A burst that corrupts a run of consecutive output symbols therefore lands on many different first-stage codewords.

Both streams use a valid/ready handshake. The block works one frame at a time and moves through four phases: it loads 24 symbols, stores the four first-stage check symbols, sends 28 interleaved symbols, and then sends the four second-stage check symbols. A stall on the output freezes the whole sequence, and input is accepted only in the load phase.

Top module: `rsx_cross_enc`

## Requirements
- R1: While reset is high, and on the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: Exactly 24 symbols are accepted per frame. `in_ready` then stays low until all 32 symbols of that frame's output have been accepted.
- R3: Every output frame has 32 symbols, and `out_last` is 1 on the 32nd symbol only.
- R4: The first-stage check symbols are the remainder of d(x)·x^4 divided by g(x). Here the first data symbol is the highest-degree coefficient, and the check symbols take interleaver lanes 24..27, highest degree first. g(x) = (x+α^126)(x+α^127)(x+α^128)(x+α^129) over GF(2^8), where α = 0x02 and the field polynomial is x^8+x^4+x^3+x^2+1 (0x11D).
- R5: Lane i (0..27) of the interleaved frame carries lane i of the first-stage codeword from i frames earlier. Lane 0 is undelayed and lane 27 is delayed 27 frames.
- R6: A lane whose delayed source frame precedes the first frame since reset reads as 0x00.
- R7: Output symbols 0..27 are the interleaved lanes in order. Symbols 28..31 are the second-stage check symbols, computed with the same code rule as R4 over those 28 symbols.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold on the next cycle. No symbol is lost or repeated.
- R9: `in_ready` and `out_valid` are never 1 together, and `in_data` has no effect while `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol present |
| in_data | input | 8 | Input data symbol |
| in_ready | output | 1 | Block accepts an input symbol |
| out_valid | output | 1 | Output symbol present |
| out_data | output | 8 | Output symbol |
| out_last | output | 1 | Marks symbol 31 of an output frame |
| out_ready | input | 1 | Sink accepts an output symbol |

## Verification
The bench cycles through five frame patterns: all-zero, all-0xFF, a single 0x01 impulse at a moving position, a ramp, and random data. All-zero frames show whether stale interleaver contents leak into the output. The impulse frames expose a lane being delayed by the wrong number of frames. The ramp and random frames catch wrong generator coefficients or wrong check-symbol ordering. Thirty-four frames are run so that every lane passes from its zero-fill period (R6) into carrying real data. Random output stalls and junk input offered while the block is busy test R8 and R9 against a model built from per-lane queues.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
    localparam int SYM_W     = 8;
    localparam int N_DATA    = 24;
    localparam int N_PAR     = 4;
    localparam int N_MID     = N_DATA + N_PAR;
    localparam int N_OUT     = N_MID + N_PAR;
    localparam int ILV_DEPTH = N_MID - 1;
    localparam int ROOT_BASE = 126;
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [N_PAR:0]   gen_t;
    typedef enum logic [1:0] {PH_LOAD, PH_PAR1, PH_SEND, PH_PAR2} phase_e;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc = '0;
        sym_t sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic sym_t gf_pow2(input int e);
        sym_t v = 8'h01;
        for (int i = 0; i < e; i++) v = gf_mul(v, 8'h02);
        return v;
    endfunction

    // coefficient k of x^k, monic product of (x + alpha^(ROOT_BASE+j))
    function automatic gen_t gen_poly();
        gen_t c = '0;
        sym_t r;
        c[0] = 8'h01;
        for (int j = 0; j < N_PAR; j++) begin
            r = gf_pow2(ROOT_BASE + j);
            for (int k = N_PAR; k > 0; k--) c[k] = c[k-1] ^ gf_mul(r, c[k]);
            c[0] = gf_mul(r, c[0]);
        end
        return c;
    endfunction
endpackage

// File: rtl/rsx_par_enc.sv
module rsx_par_enc
    import rsx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic flush,
    input  sym_t din,
    output sym_t par_out
);
    localparam gen_t G = gen_poly();

    sym_t rem [N_PAR];
    sym_t fb;

    assign fb      = din ^ rem[N_PAR-1];
    assign par_out = rem[N_PAR-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_PAR; k++) rem[k] <= '0;
        end else if (step) begin
            if (flush) begin
                rem[0] <= '0;
                for (int k = 1; k < N_PAR; k++) rem[k] <= rem[k-1];
            end else begin
                rem[0] <= gf_mul(fb, G[0]);
                for (int k = 1; k < N_PAR; k++) rem[k] <= rem[k-1] ^ gf_mul(fb, G[k]);
            end
        end
    end
endmodule

// File: rtl/rsx_ilv_store.sv
module rsx_ilv_store
    import rsx_pkg::*;
#(
    parameter int LANES = N_MID,
    parameter int SLOTS = N_MID,
    localparam int LW = $clog2(LANES),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_lane,
    input  logic [SW-1:0] wr_slot,
    input  sym_t          wr_sym,
    input  logic [LW-1:0] rd_lane,
    input  logic [SW-1:0] rd_slot,
    output sym_t          rd_sym
);
    sym_t mem [SLOTS][LANES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot][wr_lane] <= wr_sym;
    end

    assign rd_sym = mem[rd_slot][rd_lane];
endmodule

// File: rtl/rsx_cross_enc.sv
module rsx_cross_enc
    import rsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int CW = $clog2(N_MID);
    typedef logic [CW-1:0] idx_t;

    phase_e phase;
    idx_t   cnt, slot, filled, wr_lane, rd_slot;
    logic   fire_in, fire_out, wr_en;
    sym_t   enc1_par, enc2_par, wr_sym, rd_sym, mid_sym;
    int     rd_calc;

    assign in_ready  = (phase == PH_LOAD);
    assign out_valid = (phase == PH_SEND) || (phase == PH_PAR2);
    assign fire_in   = in_valid && in_ready;
    assign fire_out  = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_LOAD;
            cnt    <= '0;
            slot   <= '0;
            filled <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: if (fire_in) begin
                    if (cnt == idx_t'(N_DATA-1)) begin phase <= PH_PAR1; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                PH_PAR1: begin
                    if (cnt == idx_t'(N_PAR-1)) begin phase <= PH_SEND; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                PH_SEND: if (fire_out) begin
                    if (cnt == idx_t'(N_MID-1)) begin phase <= PH_PAR2; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                PH_PAR2: if (fire_out) begin
                    if (cnt == idx_t'(N_PAR-1)) begin
                        phase  <= PH_LOAD;
                        cnt    <= '0;
                        slot   <= (slot == idx_t'(N_MID-1)) ? '0 : slot + 1'b1;
                        if (filled != idx_t'(ILV_DEPTH)) filled <= filled + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // stage one: outer code, writes lanes into the delay store
    rsx_par_enc u_enc_outer (
        .clk(clk), .rst(rst),
        .step(fire_in || (phase == PH_PAR1)),
        .flush(phase == PH_PAR1),
        .din(in_data), .par_out(enc1_par)
    );

    assign wr_en   = fire_in || (phase == PH_PAR1);
    assign wr_lane = (phase == PH_PAR1) ? idx_t'(N_DATA) + cnt : cnt;
    assign wr_sym  = (phase == PH_PAR1) ? enc1_par : in_data;

    always_comb begin
        rd_calc = int'(slot) - int'(cnt);
        if (rd_calc < 0) rd_calc = rd_calc + N_MID;
        rd_slot = idx_t'(rd_calc);
    end

    rsx_ilv_store u_store (
        .clk(clk), .wr_en(wr_en), .wr_lane(wr_lane), .wr_slot(slot), .wr_sym(wr_sym),
        .rd_lane(cnt), .rd_slot(rd_slot), .rd_sym(rd_sym)
    );

    assign mid_sym = (cnt <= filled) ? rd_sym : '0;

    // stage two: inner code over the interleaved frame
    rsx_par_enc u_enc_inner (
        .clk(clk), .rst(rst),
        .step(fire_out),
        .flush(phase == PH_PAR2),
        .din(mid_sym), .par_out(enc2_par)
    );

    assign out_data = (phase == PH_PAR2) ? enc2_par : mid_sym;
    assign out_last = (phase == PH_PAR2) && (cnt == idx_t'(N_PAR-1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(out_last && out_ready));
    assert_in_count_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> ($past(cnt) == idx_t'(N_DATA-1)));
    assert_flushed_R4: assert property (@(posedge clk) disable iff (rst)
        (in_ready && cnt == '0) |-> (enc1_par == '0 && enc2_par == '0));
    assert_unfilled_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEND && cnt > filled) |-> (out_data == '0));
endmodule

// File: tb/rsx_cross_enc_bench.sv
module rsx_cross_enc_bench;
    localparam int NF = 34;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, in_valid, in_ready, out_valid, out_ready, out_last;
    logic [7:0] in_data, out_data;

    rsx_cross_enc u_rsx_cross_enc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0] gh [5];
    logic [7:0] lane_q [28][$];
    logic [7:0] exp_q [$];
    logic [7:0] cur [$];

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_gen();
        logic [7:0] c [5];
        logic [7:0] a = 8'h01;
        for (int k = 0; k < 5; k++) c[k] = 0;
        c[0] = 8'h01;
        for (int e = 0; e < 126; e++) a = mul(a, 8'h02);
        for (int j = 0; j < 4; j++) begin
            for (int k = 4; k > 0; k--) c[k] = c[k-1] ^ mul(a, c[k]);
            c[0] = mul(a, c[0]);
            a = mul(a, 8'h02);
        end
        for (int j = 0; j < 5; j++) gh[j] = c[4-j];
    endtask

    // long division; returns full systematic codeword in w (n data + 4 check)
    task automatic encode(input int n, inout logic [7:0] w [32]);
        logic [7:0] m [32];
        for (int i = 0; i < 32; i++) m[i] = (i < n) ? w[i] : 8'h00;
        for (int i = 0; i < n; i++)
            for (int j = 1; j < 5; j++) m[i+j] ^= mul(m[i], gh[j]);
        for (int i = n; i < n + 4; i++) w[i] = m[i];
    endtask

    task automatic model_frame();
        logic [7:0] w [32];
        for (int i = 0; i < 32; i++) w[i] = (i < 24) ? cur[i] : 8'h00;
        encode(24, w);
        for (int i = 0; i < 28; i++) begin
            lane_q[i].push_back(w[i]);
            w[i] = lane_q[i].pop_front();
        end
        for (int i = 28; i < 32; i++) w[i] = 0;
        encode(28, w);
        for (int i = 0; i < 32; i++) exp_q.push_back(w[i]);
    endtask

    function automatic logic [7:0] pattern(input int f, input int s);
        case (f % 5)
            0: return 8'h00;
            1: return 8'hFF;
            2: return (s == f % 24) ? 8'h01 : 8'h00;
            3: return 8'(s * 9 + f);
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int frames_in = 0, frames_out = 0, sym_i = 0, out_idx = 0;
        bit stalled = 0;
        logic [7:0] held = 0;
        logic [7:0] e;
        string tag;
        build_gen();
        for (int i = 0; i < 28; i++)
            for (int d = 0; d < i; d++) lane_q[i].push_back(8'h00);
        rst = 1; in_valid = 0; in_data = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {in_ready, out_valid}, 2);
        while (frames_out < NF) begin
            if (stalled) check(out_valid && out_data == held, "R8 hold", out_data, held);
            if (in_ready) begin
                in_valid = (frames_in < NF) && ($urandom % 4 != 0);
                in_data  = pattern(frames_in, sym_i);
            end else begin
                in_valid = 1'b1;
                in_data  = 8'($urandom);   // junk while busy (R9)
            end
            out_ready = ($urandom % 10) < 7;
            #1;
            check(!(in_ready && out_valid), "R9 exclusive", {in_ready, out_valid}, 0);
            if (in_valid && in_ready) begin
                cur.push_back(in_data);
                sym_i++;
                if (sym_i == 24) begin
                    model_frame();
                    frames_in++;
                    sym_i = 0;
                    cur.delete();
                end
            end
            if (out_valid && out_ready) begin
                check(exp_q.size() > 0, "R2 output before 24 inputs", exp_q.size(), 1);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
                if (out_idx >= 28)               tag = "R7 inner check";
                else if (frames_out < out_idx)   tag = "R6 unfilled lane";
                else if (out_idx >= 24)          tag = "R4 outer check lane";
                else                             tag = "R5 delayed lane";
                check(out_data == e, tag, out_data, e);
                check(out_last == (out_idx == 31), "R3 out_last", out_last, out_idx == 31);
                out_idx++;
                if (out_idx == 32) begin
                    out_idx = 0;
                    frames_out++;
                end
            end
            stalled = out_valid && !out_ready;
            held = out_data;
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R2 frame count", exp_q.size(), 0);
        summary();
    end
endmodule